// File: doc/BRIEF.md
# Row/Column Multiplexed DRAM Controller with Refresh

This controller connects a simple single-word host request port to an asynchronous DRAM array holding 4-bit words at 2048 rows by 2048 columns. A 22-bit host word address is split into a row half and a column half. Both halves are sent in turn over one 11-bit shared address bus, framed by active-low row strobe, column strobe, write strobe and output-enable lines. Every access moves a single 4-bit word. The four planes are read or written together at the same row and column.

Stored charge only lasts about 2 ms. A built-in refresh engine therefore raises a request at a fixed interval, 48 clock cycles by default. It serves one row per request, strobing only the row line with the refresh row counter on the address pins. The counter sweeps rows 0 to 2047 and then starts again. At 50 MHz the whole sweep takes about 1.97 ms. A pending refresh is served before any new host request. The host is held off with a low `host_ready` while a refresh waits or runs.

The host raises `host_req` with its address, direction and write data, and holds them until a cycle in which `host_ready` is high. That cycle accepts the request. A read returns its word on `host_rdata` together with a one-cycle `host_rvalid` pulse.

Top module: `dram_ctrl`

## Requirements
- R1: In a host access the row half `host_addr[21:11]` is on `dram_addr` in the cycle the row strobe falls, and the column half `host_addr[10:0]` is on `dram_addr` in the cycle the column strobe falls.
- R2: In a host access the row strobe is low for exactly 3 cycles. The column strobe falls exactly 1 cycle after the row strobe, stays low for exactly 2 cycles, and rises in the same cycle as the row strobe.
- R3: In a write, `dram_we_n` is low only while the column strobe is low. During that time `dram_dq_oe` is 1, `dram_oe_n` is 1 and `dram_dq_out` carries the host write data, so that a later read of the same address returns it.
- R4: In a read, `dram_we_n` stays high, and `dram_oe_n` is low with `dram_dq_oe` at 0 during the column phase. `host_rdata` holds the word present on `dram_dq_in` at the end of the column phase. `host_rvalid` is high for exactly one cycle, the first cycle after the column strobe rises.
- R5: Once the row strobe rises, it stays high for at least 2 cycles (precharge).
- R6: A refresh strobes only the row line, for exactly 2 cycles, with the column strobe high throughout and the refresh row number on `dram_addr`.
- R7: The first refresh after reset uses row 0. Each later refresh uses the next row, and row 2047 is followed by row 0.
- R8: A refresh request is raised every 48 cycles. It is served as soon as the sequencer is idle, so consecutive refreshes start between 43 and 53 cycles apart, even under continuous host requests.
- R9: `host_ready` is low while any operation is in progress or a refresh is pending. An accepted request starts its row strobe in the next cycle, never a refresh.
- R10: While reset is held, all four strobes are high, `dram_dq_oe` and `host_rvalid` are 0. In the first cycle after reset `host_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address, row in upper 11 bits |
| host_wdata | input | 4 | Write word |
| host_ready | output | 1 | Request accepted in a cycle where both are high |
| host_rdata | output | 4 | Read word |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| dram_addr | output | 11 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data to the array |
| dram_dq_oe | output | 1 | Controller drives the data lines |
| dram_dq_in | input | 4 | Data from the array |

## Verification
The in-line assertions watch the strobe ordering on every cycle: the column strobe only falls under an active row strobe, precharge follows every row strobe release, the write strobe is never active without driven data, and read-valid is a single pulse. They also check that an accepted request opens a row and that a started refresh drives the counter's row and advances it by one. What only the bench scenarios can show is end-to-end data integrity through the split address, the refresh cadence under back-to-back host traffic, and the full 2048-row sweep wrapping to row 0.

// File: rtl/dramc_pkg.sv
// Shared types for the DRAM controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dramc_pkg;

    // Sequencer phases: idle, row open, column strobe, precharge, refresh
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_CAS  = 3'd2,
        ST_PRE  = 3'd3,
        ST_REF  = 3'd4
    } seq_state_t;

    // Largest of four phase durations, used to size the phase counter
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dramc_refresh.sv
// Refresh pacing: a free-running interval timer raises a pending flag,
// and a row counter names the next row to refresh.
// Assumes the sequencer finishes any operation well within one interval,
// so no request is ever raised while the previous one is still waiting.
module dramc_refresh #(
    parameter int ROW_W    = 11,
    parameter int INTERVAL = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rfsh_start,
    input  logic             rfsh_done,
    output logic             rfsh_pending,
    output logic [ROW_W-1:0] rfsh_row
);
    localparam int TMR_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TMR_W-1:0] tmr_q;
    logic             tick;

    assign tick = (tmr_q == TMR_W'(INTERVAL - 1));

    // Interval timer: counts 0..INTERVAL-1 and restarts
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr_q <= '0;
        else if (tick) tmr_q <= '0;
        else           tmr_q <= tmr_q + 1'b1;
    end

    // Pending flag: set by the timer, cleared when the sequencer takes it
    always_ff @(posedge clk) begin
        if (!rst_n)          rfsh_pending <= 1'b0;
        else if (tick)       rfsh_pending <= 1'b1;
        else if (rfsh_start) rfsh_pending <= 1'b0;
    end

    // Row counter: advances after each completed refresh, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n)         rfsh_row <= '0;
        else if (rfsh_done) rfsh_row <= rfsh_row + 1'b1;
    end

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_done |=> (rfsh_row == ROW_W'($past(rfsh_row) + 1'b1)));

    // R8
    no_lost_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rfsh_start) |-> !rfsh_pending);

endmodule

// File: rtl/dramc_sequencer.sv
// Access sequencer: runs host reads/writes as row-then-column strobe
// sequences and row-only refresh cycles, each followed by precharge.
// Assumes row and column halves are the same width (one shared bus) and
// that a pending refresh outranks a host request when both are present.
module dramc_sequencer
    import dramc_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 11,
    parameter int DATA_W   = 4,
    parameter int RCD      = 1,
    parameter int CAS_HOLD = 2,
    parameter int PRE      = 2,
    parameter int REF_RAS  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ready,
    output logic [DATA_W-1:0]      host_rdata,
    output logic                   host_rvalid,
    input  logic                   rfsh_pending,
    input  logic [ROW_W-1:0]       rfsh_row,
    output logic                   rfsh_start,
    output logic                   rfsh_done,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    localparam int DUR_MAX = max_of4(RCD, CAS_HOLD, PRE, REF_RAS);
    localparam int CNT_W   = $clog2(DUR_MAX + 1);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last;
    logic              op_we_q;
    logic [ROW_W-1:0]  op_row_q;
    logic [COL_W-1:0]  op_col_q;
    logic [DATA_W-1:0] op_wdata_q;
    logic              accept;

    assign last       = (cnt_q == '0);
    assign host_ready = (state_q == ST_IDLE) && !rfsh_pending;
    assign accept     = host_ready && host_req;
    assign rfsh_start = (state_q == ST_IDLE) && rfsh_pending;
    assign rfsh_done  = (state_q == ST_REF) && last;

    // Phase machine and duration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (rfsh_pending) begin
                        state_q <= ST_REF;
                        cnt_q   <= CNT_W'(REF_RAS - 1);
                    end else if (host_req) begin
                        state_q <= ST_ACT;
                        cnt_q   <= CNT_W'(RCD - 1);
                    end
                end
                ST_ACT: begin
                    if (last) begin
                        state_q <= ST_CAS;
                        cnt_q   <= CNT_W'(CAS_HOLD - 1);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_CAS, ST_REF: begin
                    if (last) begin
                        state_q <= ST_PRE;
                        cnt_q   <= CNT_W'(PRE - 1);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_PRE: begin
                    if (last) state_q <= ST_IDLE;
                    else      cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operation capture: address halves, direction and data at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_we_q    <= 1'b0;
            op_row_q   <= '0;
            op_col_q   <= '0;
            op_wdata_q <= '0;
        end else if (accept) begin
            op_we_q    <= host_we;
            op_row_q   <= host_addr[ROW_W+COL_W-1:COL_W];
            op_col_q   <= host_addr[COL_W-1:0];
            op_wdata_q <= host_wdata;
        end
    end

    // Read return: sample the array at the end of the column phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= 1'b0;
            if (state_q == ST_CAS && last && !op_we_q) begin
                host_rdata  <= dram_dq_in;
                host_rvalid <= 1'b1;
            end
        end
    end

    // Pin decode from the current phase
    always_comb begin
        case (state_q)
            ST_ACT:  dram_addr = op_row_q;
            ST_CAS:  dram_addr = ROW_W'(op_col_q);
            ST_REF:  dram_addr = rfsh_row;
            default: dram_addr = '0;
        endcase
        dram_ras_n  = !(state_q == ST_ACT || state_q == ST_CAS || state_q == ST_REF);
        dram_cas_n  = !(state_q == ST_CAS);
        dram_we_n   = !(state_q == ST_CAS && op_we_q);
        dram_oe_n   = !(state_q == ST_CAS && !op_we_q);
        dram_dq_oe  = (state_q == ST_CAS) && op_we_q;
        dram_dq_out = op_wdata_q;
    end

    // R2
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (!dram_ras_n && !$past(dram_ras_n)));

    // R3
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_dq_oe && dram_oe_n && !dram_cas_n));

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R5
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |=> dram_ras_n);

    // R9
    accept_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready) |=> (!dram_ras_n && dram_cas_n && !rfsh_done));

endmodule

// File: rtl/dram_ctrl.sv
// Top of the multiplexed-address DRAM controller: joins the refresh pacer
// and the access sequencer. Assumes a single asynchronous DRAM device with
// separate data-in and data-out lines (tristating is done outside).
module dram_ctrl #(
    parameter int ROW_BITS           = 11,
    parameter int COL_BITS           = 11,
    parameter int WORD_BITS          = 4,
    parameter int REFRESH_CYCLES     = 48,
    parameter int RAS_CAS_DELAY      = 1,
    parameter int CAS_CYCLES         = 2,
    parameter int PRECHARGE_CYCLES   = 2,
    parameter int REFRESH_RAS_CYCLES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_req,
    input  logic                         host_we,
    input  logic [ROW_BITS+COL_BITS-1:0] host_addr,
    input  logic [WORD_BITS-1:0]         host_wdata,
    output logic                         host_ready,
    output logic [WORD_BITS-1:0]         host_rdata,
    output logic                         host_rvalid,
    output logic [ROW_BITS-1:0]          dram_addr,
    output logic                         dram_ras_n,
    output logic                         dram_cas_n,
    output logic                         dram_we_n,
    output logic                         dram_oe_n,
    output logic [WORD_BITS-1:0]         dram_dq_out,
    output logic                         dram_dq_oe,
    input  logic [WORD_BITS-1:0]         dram_dq_in
);
    logic                rfsh_pending;
    logic                rfsh_start;
    logic                rfsh_done;
    logic [ROW_BITS-1:0] rfsh_row;

    dramc_refresh #(
        .ROW_W    (ROW_BITS),
        .INTERVAL (REFRESH_CYCLES)
    ) u_refresh (
        .clk          (clk),
        .rst_n        (rst_n),
        .rfsh_start   (rfsh_start),
        .rfsh_done    (rfsh_done),
        .rfsh_pending (rfsh_pending),
        .rfsh_row     (rfsh_row)
    );

    dramc_sequencer #(
        .ROW_W    (ROW_BITS),
        .COL_W    (COL_BITS),
        .DATA_W   (WORD_BITS),
        .RCD      (RAS_CAS_DELAY),
        .CAS_HOLD (CAS_CYCLES),
        .PRE      (PRECHARGE_CYCLES),
        .REF_RAS  (REFRESH_RAS_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_ready   (host_ready),
        .host_rdata   (host_rdata),
        .host_rvalid  (host_rvalid),
        .rfsh_pending (rfsh_pending),
        .rfsh_row     (rfsh_row),
        .rfsh_start   (rfsh_start),
        .rfsh_done    (rfsh_done),
        .dram_addr    (dram_addr),
        .dram_ras_n   (dram_ras_n),
        .dram_cas_n   (dram_cas_n),
        .dram_we_n    (dram_we_n),
        .dram_oe_n    (dram_oe_n),
        .dram_dq_out  (dram_dq_out),
        .dram_dq_oe   (dram_dq_oe),
        .dram_dq_in   (dram_dq_in)
    );

    // R6
    refresh_row_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_start |=> (!dram_ras_n && dram_cas_n && dram_addr == $past(rfsh_row)));

endmodule

// File: tb/dram_ctrl_bench.sv
// Directed bench with a behavioural DRAM model sampled on the falling clock edge.
module dram_ctrl_bench;
    localparam int GAP_MIN = 43;
    localparam int GAP_MAX = 53;
    localparam int WDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [21:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_ready;
    logic [3:0]  host_rdata;
    logic        host_rvalid;
    logic [10:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dq_drive = '0;

    always #2 clk = ~clk;

    dram_ctrl u_dram_ctrl (
        .clk (clk), .rst_n (rst_n),
        .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_ready (host_ready),
        .host_rdata (host_rdata), .host_rvalid (host_rvalid),
        .dram_addr (dram_addr), .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
        .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
        .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dq_drive)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [3:0] model_mem [bit [21:0]];
    logic [3:0] exp_mem   [bit [21:0]];
    logic [21:0] cur_addr = '0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, act, act, exp, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(negedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
            finish_run();
        end
    end

    // DRAM model and pin-level monitor
    bit          p_ras = 1'b1, p_cas = 1'b1, cas_seen = 1'b0, wrap_seen = 1'b0;
    int          ras_lo = 0, cas_lo = 0, ras_hi = 100, ras_fall_cyc = 0;
    int          last_ref_start = -1, ref_count = 0;
    logic [10:0] lat_row = '0, exp_ref_row = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                // R5 precharge before every row strobe
                chk(ras_hi >= 2, "R5 precharge", ras_hi, 2);
                lat_row = dram_addr; ras_fall_cyc = cyc; cas_seen = 0; ras_lo = 0; cas_lo = 0;
            end
            if (!dram_ras_n) begin
                ras_lo++;
                chk(host_ready == 1'b0, "R9 ready low while busy", host_ready, 0);
            end else ras_hi++;
            if (p_cas && !dram_cas_n) begin
                cas_seen = 1;
                chk(cyc - ras_fall_cyc == 1, "R2 ras-to-cas", cyc - ras_fall_cyc, 1);
                chk(lat_row == cur_addr[21:11], "R1 row half", lat_row, cur_addr[21:11]);
                chk(dram_addr == cur_addr[10:0], "R1 column half", dram_addr, cur_addr[10:0]);
                if (!dram_we_n) begin
                    chk(dram_dq_oe && dram_oe_n, "R3 write drive", {dram_dq_oe, dram_oe_n}, 3);
                    model_mem[{lat_row, dram_addr}] = dram_dq_out;
                end else begin
                    chk(!dram_oe_n && !dram_dq_oe, "R4 read enables", {dram_dq_oe, dram_oe_n}, 0);
                    dq_drive = model_mem.exists({lat_row, dram_addr}) ? model_mem[{lat_row, dram_addr}] : 4'h0;
                end
            end
            if (!dram_cas_n) cas_lo++;
            if (host_rvalid)
                chk(!p_cas && dram_cas_n, "R4 rvalid timing", {p_cas, dram_cas_n}, 1);
            if (!p_ras && dram_ras_n) begin
                if (cas_seen) begin
                    chk(ras_lo == 3, "R2 row strobe length", ras_lo, 3);
                    chk(cas_lo == 2, "R2 column strobe length", cas_lo, 2);
                    chk(dram_cas_n == 1'b1, "R2 strobes release together", dram_cas_n, 1);
                end else begin
                    chk(ras_lo == 2, "R6 refresh strobe length", ras_lo, 2);
                    chk(lat_row == exp_ref_row, "R7 refresh row", lat_row, exp_ref_row);
                    if (lat_row == 11'd0 && ref_count > 0) wrap_seen = 1;
                    if (last_ref_start >= 0)
                        chk(ras_fall_cyc - last_ref_start >= GAP_MIN &&
                            ras_fall_cyc - last_ref_start <= GAP_MAX,
                            "R8 refresh spacing", ras_fall_cyc - last_ref_start, 48);
                    last_ref_start = ras_fall_cyc;
                    exp_ref_row = exp_ref_row + 1'b1;
                    ref_count++;
                end
                ras_hi = 0;
            end
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
        end
    end

    // One host transfer; returns read data
    task automatic host_op(input bit w, input logic [21:0] a, input logic [3:0] d,
                           output logic [3:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        while (!host_ready) @(negedge clk);
        @(posedge clk);
        cur_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        rd = 4'h0;
        if (!w) begin
            bit got = 0;
            for (int k = 0; k < 12 && !got; k++) begin
                if (host_rvalid) begin got = 1; rd = host_rdata; end
                else @(negedge clk);
            end
            chk(got, "R4 rvalid arrives", got, 1);
            @(negedge clk);
            chk(!host_rvalid, "R4 rvalid single cycle", host_rvalid, 0);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R10 strobes idle",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !host_rvalid, "R10 drive and valid low", {dram_dq_oe, host_rvalid}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1, "R10 ready after reset", host_ready, 1);
    endtask

    task automatic t_corners;
        logic [21:0] a [4] = '{22'h000000, 22'h3FFFFF, 22'h155555, 22'h2AAAAA};
        logic [3:0]  d [4] = '{4'h5, 4'hA, 4'hF, 4'h3};
        logic [3:0]  rd;
        for (int i = 0; i < 4; i++) host_op(1'b1, a[i], d[i], rd);
        for (int i = 0; i < 4; i++) begin
            host_op(1'b0, a[i], 4'h0, rd);
            chk(rd == d[i], "R3 R4 corner readback", rd, d[i]);
        end
        host_op(1'b1, 22'h155555, 4'h6, rd);
        host_op(1'b0, 22'h155555, 4'h0, rd);
        chk(rd == 4'h6, "R3 overwrite readback", rd, 6);
        host_op(1'b0, 22'h000800, 4'h0, rd);
        chk(rd == 4'h0, "R1 row-only neighbour untouched", rd, 0);
    endtask

    task automatic t_stress;
        logic [3:0] rd;
        for (int i = 0; i < 240; i++) begin
            logic [21:0] a = 22'((i * 32'h2F5A3 + 7));
            logic [3:0]  d = 4'(i ^ (i >> 3));
            host_op(1'b1, a, d, rd);
            exp_mem[a] = d;
        end
        foreach (exp_mem[k]) begin
            host_op(1'b0, k, 4'h0, rd);
            chk(rd == exp_mem[k], "R9 readback under refresh traffic", rd, exp_mem[k]);
        end
        chk(ref_count > 20, "R8 refresh kept running under load", ref_count, 21);
    endtask

    task automatic t_wrap;
        logic [3:0] rd;
        host_op(1'b1, 22'h2F0F0F, 4'h9, rd);
        while (ref_count < 2050) @(negedge clk);
        chk(wrap_seen, "R7 row counter wraps to 0", wrap_seen, 1);
        host_op(1'b0, 22'h2F0F0F, 4'h0, rd);
        chk(rd == 4'h9, "R4 data after full sweep", rd, 9);
    endtask

    initial begin
        t_reset();
        t_corners();
        t_stress();
        t_wrap();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule